// File: doc/BRIEF.md
# GFSK Carrier Frequency Word Generator

This block converts a raw NRZ transmit bit stream into a stream of synthesizer frequency words. It forms the channel centre from a two-bit band code and a channel number, then offsets the centre by a deviation that follows a Gaussian-shaped trajectory. The deviation does not jump between the two tones. Each output word is unsigned, 24 bits wide, with 100 Hz per LSB, so 928 MHz fits with margin.

A bit strobe marks each new data bit. Internally every bit is split into 8 samples, one every `SAMP_DIV` clocks. The samples pass through a 24-tap symmetric integer FIR that spans three bit periods and is shaped for a bandwidth-time product of 0.5. The taps sum to exactly 192, so a long run of equal bits settles at exactly ±19.2 kHz. The output is a timed modulation track and has no back-pressure: a new word is registered on every clock, and `freq_vld` only states whether the band code is legal. The downstream synthesizer must accept every word.

Top module: `gfsk_freq_word_gen`

## Requirements
- R1: Band code 3 is illegal: one clock after it is applied, `freq_vld` is 0 and `freq_word` is 0. Codes 0, 1 and 2 give `freq_vld` = 1 and use channel bases 4331520, 8681856 and 9020928 LSB (433.152, 868.1856 and 902.0928 MHz).
- R2: Channel centre = band base + `chan_num` × 1536 LSB (153.6 kHz spacing at 100 Hz/LSB). This holds for every channel number from 0 to 255.
- R3: While `mod_en` is 0, `freq_word` is the plain centre. The shaping history and the held bit are both loaded with `tx_data` on every clock, and the sample divider is held at its start.
- R4: While enabled, `bit_stb` = 1 captures `tx_data` as the current bit and restarts the sample divider. A sample shifts the current bit into the history once every `SAMP_DIV` clocks, on the clock where the divider reaches `SAMP_DIV`-1. A strobe on that same clock still lets the old bit shift.
- R5: Deviation in LSB = sum over k = 0..23 of h[k]·(+1 if history sample k is 1, else −1). The taps h are 0,0,0,0,0,1,1,4,9,18,28,35 for k = 0..11 and mirror for k = 12..23 (h[k] = h[23−k]). Sample 0 is the newest.
- R6: After 24 samples of identical bits, the word is exactly centre + 192 for ones and centre − 192 for zeros (±19.2 kHz).
- R7: `freq_word` is registered. The word after a clock edge reflects the band, channel and enable inputs and the history as they were before that edge.
- R8: While enabled with a legal band, |`freq_word` − centre| never exceeds 192. Alternating data stays strictly below 192.
- R9: During reset, `freq_word` is 0 and `freq_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_en | input | 1 | 1 = apply shaped deviation, 0 = plain centre |
| band_sel | input | 2 | Band code: 0, 1, 2 legal, 3 illegal |
| chan_num | input | CH_W (8) | Channel number |
| tx_data | input | 1 | NRZ transmit bit |
| bit_stb | input | 1 | One-clock pulse marking a new bit |
| freq_word | output | 24 | Frequency word, 100 Hz per LSB |
| freq_vld | output | 1 | Band code legal for the current word |

## Verification
The bench sweeps every band code against every channel number with modulation off. An error in the spacing multiply or in a base constant then shows up as a wrong centre on a specific channel, and a missed illegal-code check shows up as a nonzero word. With modulation on, it drives long runs, alternating bits, pseudo-random data and strobes off the regular grid, and compares every cycle against a convolution it computes itself. A mirrored or misplaced tap, a shift on the wrong divider phase, or a strobe that overwrites the bit before its last sample would move the trajectory by at least one LSB. It also checks the first word after enable and the exact ±192 plateau, which a tap set that does not sum to 192 would miss.

// File: rtl/gfsk_pkg.sv
package gfsk_pkg;
  localparam int FW           = 24;   // frequency word width
  localparam int SPB          = 8;    // samples per bit
  localparam int SPAN         = 3;    // bits spanned by the pulse
  localparam int NTAPS        = SPB * SPAN;
  localparam int DEV_W        = 10;
  localparam int DEV_NOM      = 192;  // 19.2 kHz at 100 Hz/LSB
  localparam int SPACING      = 1536; // 153.6 kHz
  localparam logic [FW-1:0] BASE_LO  = 24'd4331520;
  localparam logic [FW-1:0] BASE_MID = 24'd8681856;
  localparam logic [FW-1:0] BASE_HI  = 24'd9020928;

  typedef enum logic [1:0] {
    BAND_LO   = 2'b00,
    BAND_MID  = 2'b01,
    BAND_HI   = 2'b10,
    BAND_NONE = 2'b11
  } band_e;

  // Gaussian (BT = 0.5) weights, symmetric, summing to DEV_NOM
  function automatic int tap_w(input int k);
    int m;
    m = (k < NTAPS / 2) ? k : (NTAPS - 1 - k);
    case (m)
      11:      return 35;
      10:      return 28;
      9:       return 18;
      8:       return 9;
      7:       return 4;
      6:       return 1;
      5:       return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/gfsk_chan_centre.sv
module gfsk_chan_centre
  import gfsk_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic [1:0]      band_sel,
  input  logic [CH_W-1:0] chan_num,
  output logic [FW-1:0]   centre,
  output logic            band_ok
);
  logic [FW-1:0] base;
  logic [FW-1:0] offs;

  always_comb begin
    band_ok = 1'b1;
    case (band_e'(band_sel))
      BAND_LO:  base = BASE_LO;
      BAND_MID: base = BASE_MID;
      BAND_HI:  base = BASE_HI;
      default: begin
        base    = '0;
        band_ok = 1'b0;
      end
    endcase
    offs   = FW'(chan_num) * FW'(SPACING);
    centre = base + offs;
  end
endmodule

// File: rtl/gfsk_sample_tick.sv
module gfsk_sample_tick #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic realign,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (!en || realign)       cnt <= '0;
    else if (cnt == LAST)          cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((DIV > 1) && tick && !realign) |=> !tick); // R4
endmodule

// File: rtl/gfsk_gauss_fir.sv
module gfsk_gauss_fir
  import gfsk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    fill_bit,
  input  logic                    shift,
  input  logic                    in_bit,
  output logic signed [DEV_W-1:0] dev
);
  logic [NTAPS-1:0] hist;
  logic signed [DEV_W-1:0] term [NTAPS];

  always_ff @(posedge clk) begin
    if (!rst_n)      hist <= '0;
    else if (!en)    hist <= {NTAPS{fill_bit}};
    else if (shift)  hist <= {hist[NTAPS-2:0], in_bit};
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam logic signed [DEV_W-1:0] W = DEV_W'(tap_w(k));
    assign term[k] = hist[k] ? W : -W;
  end

  always_comb begin
    dev = '0;
    for (int k = 0; k < NTAPS; k++) dev = dev + term[k];
  end

  AST_DEV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (dev <= DEV_NOM) && (dev >= -DEV_NOM)); // R8
  AST_STEADY_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (&hist) |-> (dev == DEV_NOM)); // R6
  AST_STEADY_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (hist == '0) |-> (dev == -DEV_NOM)); // R6
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($countones(hist) == 0 || $countones(hist) == NTAPS)); // R3
endmodule

// File: rtl/gfsk_freq_word_gen.sv
module gfsk_freq_word_gen
  import gfsk_pkg::*;
#(
  parameter int CH_W     = 8,
  parameter int SAMP_DIV = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mod_en,
  input  logic [1:0]      band_sel,
  input  logic [CH_W-1:0] chan_num,
  input  logic            tx_data,
  input  logic            bit_stb,
  output logic [FW-1:0]   freq_word,
  output logic            freq_vld
);
  localparam int MAX_WORD = int'(BASE_HI) + ((1 << CH_W) - 1) * SPACING + DEV_NOM;
  localparam int MIN_WORD = int'(BASE_LO) - DEV_NOM;

  logic [FW-1:0]           centre;
  logic                    band_ok;
  logic                    tick;
  logic                    cur_bit;
  logic signed [DEV_W-1:0] dev;
  logic signed [FW:0]      shaped;

  gfsk_chan_centre #(.CH_W(CH_W)) u_centre (
    .band_sel (band_sel),
    .chan_num (chan_num),
    .centre   (centre),
    .band_ok  (band_ok)
  );

  gfsk_sample_tick #(.DIV(SAMP_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (mod_en),
    .realign (bit_stb),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 cur_bit <= 1'b0;
    else if (!mod_en || bit_stb) cur_bit <= tx_data;
  end

  gfsk_gauss_fir u_fir (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (mod_en),
    .fill_bit (tx_data),
    .shift    (tick),
    .in_bit   (cur_bit),
    .dev      (dev)
  );

  assign shaped = $signed({1'b0, centre}) + (FW+1)'(dev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_word <= '0;
      freq_vld  <= 1'b0;
    end else begin
      freq_vld <= band_ok;
      if (!band_ok)    freq_word <= '0;
      else if (mod_en) freq_word <= shaped[FW-1:0];
      else             freq_word <= centre;
    end
  end

  AST_BAND_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (band_sel == 2'b11) |=> (!freq_vld && freq_word == '0)); // R1
  AST_WORD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    freq_vld |-> (int'(freq_word) >= MIN_WORD && int'(freq_word) <= MAX_WORD)); // R2
endmodule

// File: tb/gfsk_freq_word_gen_bench.sv
module gfsk_freq_word_gen_bench;
  localparam int DIV = 2;
  localparam int BIT_CYC = 8 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0;
  logic [1:0]  band_sel = 2'd0;
  logic [7:0]  chan_num = 8'd0;
  logic        tx_data = 1'b0;
  logic        bit_stb = 1'b0;
  logic [23:0] freq_word;
  logic        freq_vld;

  int n_tests = 0;
  int n_fail = 0;
  bit chk_on = 1'b0;
  string tag = "R9";

  gfsk_freq_word_gen #(.CH_W(8), .SAMP_DIV(DIV)) u_gfsk_freq_word_gen (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .band_sel(band_sel),
    .chan_num(chan_num), .tx_data(tx_data), .bit_stb(bit_stb),
    .freq_word(freq_word), .freq_vld(freq_vld)
  );

  always #5 clk = ~clk;

  function automatic int weight(input int k);
    int w [12] = '{0, 0, 0, 0, 0, 1, 1, 4, 9, 18, 28, 35};
    return (k < 12) ? w[k] : w[23 - k];
  endfunction

  function automatic int base_of(input int b);
    case (b)
      0: return 4331520;
      1: return 8681856;
      2: return 9020928;
      default: return 0;
    endcase
  endfunction

  // reference state built from the requirements
  bit m_hist [24];
  bit m_bit;
  int m_cnt;
  int exp_word;
  bit exp_vld;
  int exp_centre;
  bit exp_mod;

  always @(posedge clk) begin
    int dev;
    bit ok;
    bit tk;
    ok = (band_sel != 2'd3);
    dev = 0;
    for (int k = 0; k < 24; k++) dev += m_hist[k] ? weight(k) : -weight(k);
    exp_centre = base_of(int'(band_sel)) + int'(chan_num) * 1536;
    exp_mod = mod_en && ok && rst_n;
    if (!rst_n) begin
      exp_word = 0; exp_vld = 0;
      for (int k = 0; k < 24; k++) m_hist[k] = 0;
      m_bit = 0; m_cnt = 0;
    end else begin
      exp_vld = ok;
      exp_word = !ok ? 0 : (mod_en ? exp_centre + dev : exp_centre);
      if (!mod_en) begin
        for (int k = 0; k < 24; k++) m_hist[k] = tx_data;
        m_bit = tx_data; m_cnt = 0;
      end else begin
        tk = (m_cnt == DIV - 1);
        if (tk) begin
          for (int k = 23; k > 0; k--) m_hist[k] = m_hist[k-1];
          m_hist[0] = m_bit;
        end
        if (bit_stb) m_bit = tx_data;
        m_cnt = (bit_stb || tk) ? 0 : m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      n_tests++;
      if (freq_word !== 24'(exp_word) || freq_vld !== exp_vld) begin
        n_fail++;
        $display("FAIL %s: word=%0d vld=%0b expected word=%0d vld=%0b",
                 tag, freq_word, freq_vld, exp_word, exp_vld);
      end
      if (exp_mod) begin
        int d;
        n_tests++;
        d = int'(freq_word) - exp_centre;
        if (d > 192 || d < -192) begin
          n_fail++;
          $display("FAIL R8: deviation=%0d expected magnitude <= 192", d);
        end
      end
    end
  end

  task automatic send_bit(input bit b, input int len);
    @(negedge clk); tx_data = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
    repeat (len - 1) @(negedge clk);
  endtask

  task automatic direct(input string rq, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int c0;
    @(posedge clk);
    chk_on = 1'b1;
    repeat (3) @(negedge clk);
    tag = "R9";
    direct("R9", int'(freq_word), 0);
    direct("R9", int'(freq_vld), 0);
    rst_n = 1'b1;

    // R2 / R1 / R3: full sweep with modulation off
    for (int b = 0; b < 4; b++) begin
      for (int c = 0; c < 256; c++) begin
        tag = (b == 3) ? "R1" : "R2";
        band_sel = 2'(b); chan_num = 8'(c); tx_data = c[0];
        @(negedge clk);
      end
    end

    // R3 and R6: enable after a flushed run of ones
    tag = "R3"; band_sel = 2'd1; chan_num = 8'd5; tx_data = 1'b1;
    repeat (4) @(negedge clk);
    c0 = 8681856 + 5 * 1536;
    direct("R3", int'(freq_word), c0);
    @(negedge clk); mod_en = 1'b1;
    @(negedge clk);
    direct("R6", int'(freq_word), c0 + 192);
    tag = "R6";
    for (int i = 0; i < 6; i++) send_bit(1'b0, BIT_CYC);
    direct("R6", int'(freq_word), c0 - 192);
    for (int i = 0; i < 6; i++) send_bit(1'b1, BIT_CYC);
    direct("R6", int'(freq_word), c0 + 192);

    // R5 / R8: alternating data never reaches the plateau
    tag = "R5,R8";
    for (int i = 0; i < 12; i++) send_bit(i[0], BIT_CYC);
    n_tests++;
    if (freq_word == 24'(c0 + 192) || freq_word == 24'(c0 - 192)) begin
      n_fail++;
      $display("FAIL R8: word=%0d expected strictly inside centre+-192", freq_word);
    end

    // R5 / R7: pseudo-random data on several bands and channels
    tag = "R5,R7";
    lfsr = 16'hACE1;
    for (int seg = 0; seg < 3; seg++) begin
      band_sel = 2'(seg); chan_num = 8'(seg * 97 + 3);
      for (int i = 0; i < 40; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        send_bit(lfsr[0], BIT_CYC);
      end
    end

    // R4: strobes off the regular grid, including on a sample clock
    tag = "R4";
    for (int i = 0; i < 30; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send_bit(lfsr[1], 3 + int'(lfsr[5:2]));
    end

    // R1 while modulating
    tag = "R1"; band_sel = 2'd3;
    repeat (5) send_bit(1'b0, BIT_CYC);
    band_sel = 2'd2; chan_num = 8'd255; tag = "R2";
    repeat (5) send_bit(1'b1, BIT_CYC);

    // R3: disable returns to plain centre
    tag = "R3"; mod_en = 1'b0;
    repeat (4) @(negedge clk);
    direct("R3", int'(freq_word), 9020928 + 255 * 1536);

    chk_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule